// File: doc/BRIEF.md
# CCD Readout Clock Sequencer

This block produces the logic-level timing that reads one frame out of a three-phase charge-coupled image sensor. It drives three vertical gate clocks that move whole lines toward the serial output register. It also drives three horizontal gate clocks that walk that register toward the sense node. Around every output pixel it places a sense-node reset pulse and the two strobes of correlated double sampling: a reference sample taken just after the reset, and a signal sample taken once the charge has landed on the node.

The frame size is programmed as output lines and output pixels per line, each split into an image part and an overscan part that is read after it. The vertical binning factor sets how many line transfers are merged into one output line. The horizontal binning factor sets how many column transfers feed the sense node before each sample pair. A common window length sets how long both sample strobes stay high. A single-cycle start launches a frame. The configuration is captured on that start, and a one-cycle done marks the end of the frame. A zero-exposure blank frame is simply a second start issued immediately after done.

Each phase step lasts a parameterised number of system clocks, with a floor of two, so the gate potentials never change faster than that.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset and whenever no frame is running, phase 1 of both clock groups is high while phases 2 and 3 are low. In a 3-bit phase bus, bit 0 is phase 1, bit 1 is phase 2 and bit 2 is phase 3. Reset pulse, both sample strobes and done are low.
- R2: One transfer is three steps of STEP_CYC cycles each, in the order phase 1, phase 2, phase 3. Exactly one phase of a group is high at any time. Phases 2 and 3 each stay high for exactly STEP_CYC cycles per transfer.
- R3: At most one of the following is active in any cycle: vertical clocks away from rest, horizontal clocks away from rest, reset pulse, reference strobe, signal strobe.
- R4: Each output line begins with vbin vertical transfers, followed by the readout of every pixel of that line.
- R5: Each output pixel consists of, in this order: a reset pulse of STEP_CYC cycles, a reference strobe of W cycles, hbin horizontal transfers, and a signal strobe of W cycles. W is the programmed window length.
- R6: A frame reads rows + overscan rows output lines of cols + overscan cols pixels each. The overscan lines and pixels carry the same strobes as image ones.
- R7: A binning factor or window length programmed as 0 behaves as 1.
- R8: Done is high for exactly one cycle. It rises NL*(3*STEP_CYC*vbin + NP*(STEP_CYC + 2*W + 3*STEP_CYC*hbin)) cycles after the clock edge that accepted start. NL is the line total and NP is the pixel total.
- R9: A start that arrives while a frame is running is ignored: frame length and done count are unchanged.
- R10: The configuration is captured on the accepted start, so changes made during a frame have no effect on it.
- R11: A start given in the cycle after done is accepted and produces an identical frame (blank readout).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one frame (accepted only when idle) |
| cfg_rows | input | ROW_W | Image output lines |
| cfg_ovs_rows | input | ROW_W | Overscan output lines after the image |
| cfg_cols | input | COL_W | Image output pixels per line |
| cfg_ovs_cols | input | COL_W | Overscan output pixels per line |
| cfg_vbin | input | BIN_W | Line transfers per output line (0 means 1) |
| cfg_hbin | input | BIN_W | Column transfers per output pixel (0 means 1) |
| cfg_win | input | WIN_W | Sample strobe length in cycles (0 means 1) |
| v_clk | output | 3 | Vertical gate clocks, bit 0 is phase 1 |
| h_clk | output | 3 | Horizontal gate clocks, bit 0 is phase 1 |
| sn_reset | output | 1 | Sense-node reset pulse |
| cds_ref | output | 1 | Reference sample strobe |
| cds_sig | output | 1 | Signal sample strobe |
| frame_done | output | 1 | One-cycle end-of-frame marker |

## Verification
The properties assume a frame never has zero lines or zero pixels, meaning rows plus overscan rows and cols plus overscan cols are both at least one. They also assume STEP_CYC is at least two. The stimulus enforces this by always drawing at least one image line and one image pixel, and by keeping the default step length of three. Binning factors and windows are drawn over a small range that includes zero, so the substitution of one for zero is exercised. The configuration inputs are scrambled after every accepted start, and a spurious start is injected mid-frame.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_VSH   = 3'd1,
    ST_RST   = 3'd2,
    ST_SMP_R = 3'd3,
    ST_HSH   = 3'd4,
    ST_SMP_S = 3'd5
  } seq_st_e;

  // Step index 0..2 to gate pattern; bit 0 is phase 1.
  function automatic logic [2:0] step_pattern(logic [1:0] idx);
    case (idx)
      2'd0:    step_pattern = 3'b001;
      2'd1:    step_pattern = 3'b010;
      default: step_pattern = 3'b100;
    endcase
  endfunction

endpackage

// File: rtl/ccd_seq_cfg.sv
module ccd_seq_cfg #(
  parameter int ROW_W = 10,
  parameter int COL_W = 11,
  parameter int BIN_W = 4,
  parameter int WIN_W = 6,
  localparam int LINE_W = ROW_W + 1,
  localparam int PIX_W  = COL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ROW_W-1:0]  rows,
  input  logic [ROW_W-1:0]  ovs_rows,
  input  logic [COL_W-1:0]  cols,
  input  logic [COL_W-1:0]  ovs_cols,
  input  logic [BIN_W-1:0]  vbin,
  input  logic [BIN_W-1:0]  hbin,
  input  logic [WIN_W-1:0]  win,
  output logic [LINE_W-1:0] n_lines,
  output logic [PIX_W-1:0]  n_pix,
  output logic [BIN_W-1:0]  vbin_q,
  output logic [BIN_W-1:0]  hbin_q,
  output logic [WIN_W-1:0]  win_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      n_lines <= LINE_W'(1);
      n_pix   <= PIX_W'(1);
      vbin_q  <= BIN_W'(1);
      hbin_q  <= BIN_W'(1);
      win_q   <= WIN_W'(1);
    end else if (capture) begin
      n_lines <= LINE_W'(rows) + LINE_W'(ovs_rows);
      n_pix   <= PIX_W'(cols) + PIX_W'(ovs_cols);
      vbin_q  <= (vbin == '0) ? BIN_W'(1) : vbin;
      hbin_q  <= (hbin == '0) ? BIN_W'(1) : hbin;
      win_q   <= (win  == '0) ? WIN_W'(1) : win;
    end
  end

endmodule

// File: rtl/ccd_phase_drv.sv
module ccd_phase_drv (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic [1:0] idx,
  output logic [2:0] phase_q
);
  import ccd_seq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)         phase_q <= 3'b001;
    else if (active) phase_q <= step_pattern(idx);
    else             phase_q <= 3'b001;
  end

endmodule

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl #(
  parameter int STEP_CYC = 3,
  parameter int LINE_W   = 11,
  parameter int PIX_W    = 12,
  parameter int BIN_W    = 4,
  parameter int WIN_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LINE_W-1:0] n_lines,
  input  logic [PIX_W-1:0]  n_pix,
  input  logic [BIN_W-1:0]  vbin,
  input  logic [BIN_W-1:0]  hbin,
  input  logic [WIN_W-1:0]  win,
  output logic              accept,
  output logic              v_act_n,
  output logic              h_act_n,
  output logic [1:0]        step_n,
  output logic              rst_q,
  output logic              ref_q,
  output logic              sig_q,
  output logic              done_q
);
  import ccd_seq_pkg::*;

  localparam int STEP_W = (STEP_CYC > 2) ? $clog2(STEP_CYC) : 1;
  localparam int TMR_W  = (WIN_W > STEP_W) ? WIN_W : STEP_W;
  localparam logic [TMR_W-1:0] STEP_LOAD = TMR_W'(STEP_CYC - 1);

  seq_st_e           st, st_n;
  logic [1:0]        ph, ph_n;
  logic [TMR_W-1:0]  tmr, tmr_n;
  logic [BIN_W-1:0]  bcnt, bcnt_n;
  logic [PIX_W-1:0]  pcnt, pcnt_n;
  logic [LINE_W-1:0] lcnt, lcnt_n;
  logic              fin;
  logic [BIN_W-1:0]  bin_lim;
  logic [TMR_W-1:0]  win_load;

  assign win_load = TMR_W'(win) - TMR_W'(1);
  assign bin_lim  = ((st == ST_VSH) ? vbin : hbin) - BIN_W'(1);

  always_comb begin
    st_n   = st;
    ph_n   = ph;
    tmr_n  = tmr;
    bcnt_n = bcnt;
    pcnt_n = pcnt;
    lcnt_n = lcnt;
    fin    = 1'b0;
    accept = (st == ST_IDLE) && start;
    if (st != ST_IDLE && tmr != '0) tmr_n = tmr - TMR_W'(1);
    case (st)
      ST_IDLE: begin
        if (start) begin
          st_n   = ST_VSH;
          tmr_n  = STEP_LOAD;
          ph_n   = 2'd0;
          bcnt_n = '0;
          pcnt_n = '0;
          lcnt_n = '0;
        end
      end
      ST_VSH, ST_HSH: begin
        if (tmr == '0) begin
          tmr_n = STEP_LOAD;
          if (ph != 2'd2) begin
            ph_n = ph + 2'd1;
          end else begin
            ph_n = 2'd0;
            if (bcnt != bin_lim) begin
              bcnt_n = bcnt + BIN_W'(1);
            end else begin
              bcnt_n = '0;
              if (st == ST_VSH) begin
                st_n = ST_RST;
              end else begin
                st_n  = ST_SMP_S;
                tmr_n = win_load;
              end
            end
          end
        end
      end
      ST_RST: begin
        if (tmr == '0) begin
          st_n  = ST_SMP_R;
          tmr_n = win_load;
        end
      end
      ST_SMP_R: begin
        if (tmr == '0) begin
          st_n  = ST_HSH;
          tmr_n = STEP_LOAD;
        end
      end
      ST_SMP_S: begin
        if (tmr == '0) begin
          tmr_n = STEP_LOAD;
          if (pcnt == n_pix - PIX_W'(1)) begin
            pcnt_n = '0;
            if (lcnt == n_lines - LINE_W'(1)) begin
              st_n = ST_IDLE;
              fin  = 1'b1;
            end else begin
              lcnt_n = lcnt + LINE_W'(1);
              st_n   = ST_VSH;
            end
          end else begin
            pcnt_n = pcnt + PIX_W'(1);
            st_n   = ST_RST;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign v_act_n = (st_n == ST_VSH);
  assign h_act_n = (st_n == ST_HSH);
  assign step_n  = ph_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ph     <= 2'd0;
      tmr    <= '0;
      bcnt   <= '0;
      pcnt   <= '0;
      lcnt   <= '0;
      rst_q  <= 1'b0;
      ref_q  <= 1'b0;
      sig_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st     <= st_n;
      ph     <= ph_n;
      tmr    <= tmr_n;
      bcnt   <= bcnt_n;
      pcnt   <= pcnt_n;
      lcnt   <= lcnt_n;
      rst_q  <= (st_n == ST_RST);
      ref_q  <= (st_n == ST_SMP_R);
      sig_q  <= (st_n == ST_SMP_S);
      done_q <= fin;
    end
  end

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq #(
  parameter int STEP_CYC = 3,
  parameter int ROW_W    = 10,
  parameter int COL_W    = 11,
  parameter int BIN_W    = 4,
  parameter int WIN_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ROW_W-1:0] cfg_rows,
  input  logic [ROW_W-1:0] cfg_ovs_rows,
  input  logic [COL_W-1:0] cfg_cols,
  input  logic [COL_W-1:0] cfg_ovs_cols,
  input  logic [BIN_W-1:0] cfg_vbin,
  input  logic [BIN_W-1:0] cfg_hbin,
  input  logic [WIN_W-1:0] cfg_win,
  output logic [2:0]       v_clk,
  output logic [2:0]       h_clk,
  output logic             sn_reset,
  output logic             cds_ref,
  output logic             cds_sig,
  output logic             frame_done
);

  // Step length floor keeps gate transitions no faster than two clocks.
  localparam int STEP_EFF = (STEP_CYC < 2) ? 2 : STEP_CYC;
  localparam int LINE_W   = ROW_W + 1;
  localparam int PIX_W    = COL_W + 1;

  logic [LINE_W-1:0] n_lines;
  logic [PIX_W-1:0]  n_pix;
  logic [BIN_W-1:0]  vbin_q, hbin_q;
  logic [WIN_W-1:0]  win_q;
  logic              accept;
  logic [1:0]        act_n;
  logic [1:0]        step_n;
  logic [2:0]        phase_bus [2];

  ccd_seq_cfg #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BIN_W(BIN_W), .WIN_W(WIN_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .capture(accept),
    .rows(cfg_rows), .ovs_rows(cfg_ovs_rows),
    .cols(cfg_cols), .ovs_cols(cfg_ovs_cols),
    .vbin(cfg_vbin), .hbin(cfg_hbin), .win(cfg_win),
    .n_lines(n_lines), .n_pix(n_pix),
    .vbin_q(vbin_q), .hbin_q(hbin_q), .win_q(win_q)
  );

  ccd_seq_ctrl #(
    .STEP_CYC(STEP_EFF), .LINE_W(LINE_W), .PIX_W(PIX_W),
    .BIN_W(BIN_W), .WIN_W(WIN_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .n_lines(n_lines), .n_pix(n_pix),
    .vbin(vbin_q), .hbin(hbin_q), .win(win_q),
    .accept(accept),
    .v_act_n(act_n[0]), .h_act_n(act_n[1]), .step_n(step_n),
    .rst_q(sn_reset), .ref_q(cds_ref), .sig_q(cds_sig),
    .done_q(frame_done)
  );

  // Index 0 drives the vertical group, index 1 the horizontal group.
  for (genvar g = 0; g < 2; g++) begin : g_grp
    ccd_phase_drv u_drv (
      .clk(clk), .rst(rst), .active(act_n[g]), .idx(step_n),
      .phase_q(phase_bus[g])
    );
  end

  assign v_clk = phase_bus[0];
  assign h_clk = phase_bus[1];

endmodule

// File: rtl/ccd_seq_checker.sv
module ccd_seq_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] v_clk,
  input logic [2:0] h_clk,
  input logic       sn_reset,
  input logic       cds_ref,
  input logic       cds_sig,
  input logic       frame_done
);

  p_onehot_v_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(v_clk) == 1);

  p_onehot_h_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(h_clk) == 1);

  p_v_order2_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(v_clk[1]) |-> $past(v_clk[0]));

  p_v_order3_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(v_clk[2]) |-> $past(v_clk[1]));

  p_h_order2_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(h_clk[1]) |-> $past(h_clk[0]));

  p_h_order3_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(h_clk[2]) |-> $past(h_clk[1]));

  p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({v_clk != 3'b001, h_clk != 3'b001, sn_reset, cds_ref, cds_sig}));

  p_ref_after_reset_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cds_ref) |-> $past(sn_reset));

  p_sig_after_shift_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cds_sig) |-> $past(h_clk[2]));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  p_done_at_rest_r1: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (v_clk == 3'b001 && h_clk == 3'b001 &&
                    !sn_reset && !cds_ref && !cds_sig));

endmodule

bind ccd_readout_seq ccd_seq_checker u_chk (
  .clk(clk), .rst(rst), .v_clk(v_clk), .h_clk(h_clk),
  .sn_reset(sn_reset), .cds_ref(cds_ref), .cds_sig(cds_sig),
  .frame_done(frame_done)
);

// File: tb/test_ccd_readout_seq.sv
`timescale 1ns/1ps
module test_ccd_readout_seq;

  localparam int STEP  = 3;
  localparam int ROW_W = 10;
  localparam int COL_W = 11;
  localparam int BIN_W = 4;
  localparam int WIN_W = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [ROW_W-1:0] cfg_rows = '0, cfg_ovs_rows = '0;
  logic [COL_W-1:0] cfg_cols = '0, cfg_ovs_cols = '0;
  logic [BIN_W-1:0] cfg_vbin = '0, cfg_hbin = '0;
  logic [WIN_W-1:0] cfg_win = '0;
  logic [2:0]       v_clk, h_clk;
  logic             sn_reset, cds_ref, cds_sig, frame_done;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  ccd_readout_seq #(
    .STEP_CYC(STEP), .ROW_W(ROW_W), .COL_W(COL_W), .BIN_W(BIN_W), .WIN_W(WIN_W)
  ) i_ccd_readout_seq (
    .clk(clk), .rst(rst), .start(start),
    .cfg_rows(cfg_rows), .cfg_ovs_rows(cfg_ovs_rows),
    .cfg_cols(cfg_cols), .cfg_ovs_cols(cfg_ovs_cols),
    .cfg_vbin(cfg_vbin), .cfg_hbin(cfg_hbin), .cfg_win(cfg_win),
    .v_clk(v_clk), .h_clk(h_clk), .sn_reset(sn_reset),
    .cds_ref(cds_ref), .cds_sig(cds_sig), .frame_done(frame_done)
  );

  // Cumulative observation counters, sampled away from the active edge.
  int n_vrise = 0, n_hrise = 0, n_rrise = 0;
  int n_rcyc = 0, n_refcyc = 0, n_sigcyc = 0, n_done = 0;
  int n_order_err = 0, n_run_err = 0, n_excl_err = 0;
  int vrun2 = 0, vrun3 = 0, hrun2 = 0, hrun3 = 0;
  int last_ev = 0; // 0 none, 1 reset, 2 ref, 3 hshift, 4 sig, 5 vshift
  logic [2:0] pv = 3'b001, phz = 3'b001;
  logic pr = 1'b0, pref = 1'b0, psig = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (v_clk != 3'b001 && h_clk != 3'b001) n_excl_err++;
      if (sn_reset) n_rcyc++;
      if (cds_ref)  n_refcyc++;
      if (cds_sig)  n_sigcyc++;
      if (frame_done) n_done++;
      if (v_clk[1]) vrun2++;
      if (v_clk[2]) vrun3++;
      if (h_clk[1]) hrun2++;
      if (h_clk[2]) hrun3++;
      if (pv[1] && !v_clk[1]) begin if (vrun2 != STEP) n_run_err++; vrun2 = 0; end
      if (pv[2] && !v_clk[2]) begin if (vrun3 != STEP) n_run_err++; vrun3 = 0; end
      if (phz[1] && !h_clk[1]) begin if (hrun2 != STEP) n_run_err++; hrun2 = 0; end
      if (phz[2] && !h_clk[2]) begin if (hrun3 != STEP) n_run_err++; hrun3 = 0; end
      if (v_clk[1] && !pv[1]) begin
        n_vrise++;
        if (!(last_ev == 0 || last_ev == 4 || last_ev == 5)) n_order_err++;
        last_ev = 5;
      end
      if (sn_reset && !pr) begin
        n_rrise++;
        if (!(last_ev == 4 || last_ev == 5)) n_order_err++;
        last_ev = 1;
      end
      if (cds_ref && !pref) begin
        if (last_ev != 1) n_order_err++;
        last_ev = 2;
      end
      if (h_clk[1] && !phz[1]) begin
        n_hrise++;
        if (!(last_ev == 2 || last_ev == 3)) n_order_err++;
        last_ev = 3;
      end
      if (cds_sig && !psig) begin
        if (last_ev != 3) n_order_err++;
        last_ev = 4;
      end
      pv = v_clk; phz = h_clk; pr = sn_reset; pref = cds_ref; psig = cds_sig;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(v_clk == 3'b001, {tag, " v_clk at rest"}, int'(v_clk), 1);
    chk(h_clk == 3'b001, {tag, " h_clk at rest"}, int'(h_clk), 1);
    chk({sn_reset, cds_ref, cds_sig} == 3'b000, {tag, " strobes low"},
        int'({sn_reset, cds_ref, cds_sig}), 0);
  endtask

  task automatic run_frame(input int rows, input int ovr, input int cols, input int ovc,
                           input int vb, input int hb, input int w, input bit mid,
                           input string len_tag);
    int vbe, hbe, we, nl, np, d, n;
    int s_v, s_h, s_rr, s_rc, s_ref, s_sig, s_dn, s_oe, s_re, s_ee;
    bit got;
    vbe = (vb == 0) ? 1 : vb;
    hbe = (hb == 0) ? 1 : hb;
    we  = (w == 0) ? 1 : w;
    nl = rows + ovr;
    np = cols + ovc;
    d  = nl * (3 * STEP * vbe + np * (STEP + 2 * we + 3 * STEP * hbe));
    s_v = n_vrise; s_h = n_hrise; s_rr = n_rrise; s_rc = n_rcyc;
    s_ref = n_refcyc; s_sig = n_sigcyc; s_dn = n_done;
    s_oe = n_order_err; s_re = n_run_err; s_ee = n_excl_err;
    cfg_rows = ROW_W'(rows); cfg_ovs_rows = ROW_W'(ovr);
    cfg_cols = COL_W'(cols); cfg_ovs_cols = COL_W'(ovc);
    cfg_vbin = BIN_W'(vb); cfg_hbin = BIN_W'(hb); cfg_win = WIN_W'(w);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    // R10: scramble configuration while the frame runs
    cfg_rows = ROW_W'($urandom); cfg_ovs_rows = ROW_W'($urandom);
    cfg_cols = COL_W'($urandom); cfg_ovs_cols = COL_W'($urandom);
    cfg_vbin = BIN_W'($urandom); cfg_hbin = BIN_W'($urandom);
    cfg_win  = WIN_W'($urandom);
    n = 0; got = 1'b0;
    while (!got && n < d + 200) begin
      @(posedge clk); n++;
      @(negedge clk);
      start = (mid && n == d / 2); // R9: spurious start mid-frame
      if (frame_done) got = 1'b1;
    end
    start = 1'b0;
    #1;
    chk(got && n == d, {len_tag, " frame length"}, n, d);
    chk(n_done - s_dn == 1, "R8 single done pulse", n_done - s_dn, 1);
    chk(n_vrise - s_v == nl * vbe, "R4 vertical transfers", n_vrise - s_v, nl * vbe);
    chk(n_hrise - s_h == nl * np * hbe, "R5 horizontal transfers", n_hrise - s_h, nl * np * hbe);
    chk(n_rrise - s_rr == nl * np, "R6 pixel count incl overscan", n_rrise - s_rr, nl * np);
    chk(n_rcyc - s_rc == nl * np * STEP, "R5 reset pulse cycles", n_rcyc - s_rc, nl * np * STEP);
    chk(n_refcyc - s_ref == nl * np * we, "R5 reference window cycles", n_refcyc - s_ref, nl * np * we);
    chk(n_sigcyc - s_sig == nl * np * we, "R5 signal window cycles", n_sigcyc - s_sig, nl * np * we);
    chk(n_order_err == s_oe, "R5 event order", n_order_err - s_oe, 0);
    chk(n_run_err == s_re, "R2 phase step length", n_run_err - s_re, 0);
    chk(n_excl_err == s_ee, "R3 groups exclusive", n_excl_err - s_ee, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk_idle("R1 during reset");
    chk(frame_done == 1'b0, "R1 done low in reset", int'(frame_done), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R1 after reset");
    chk(frame_done == 1'b0, "R1 done low idle", int'(frame_done), 0);

    // Directed corners
    run_frame(1, 0, 1, 0, 1, 1, 1, 1'b0, "R8 minimal");
    chk_idle("R1 after frame");
    run_frame(1, 0, 1, 0, 1, 1, 1, 1'b0, "R11 blank back-to-back");
    run_frame(2, 0, 2, 0, 0, 0, 0, 1'b0, "R7 zero bin and window");
    run_frame(1, 3, 1, 4, 1, 2, 2, 1'b0, "R6 overscan heavy");
    run_frame(3, 1, 3, 1, 2, 3, 3, 1'b1, "R9 start ignored");
    run_frame(3, 1, 3, 1, 2, 3, 3, 1'b0, "R11 repeat frame");
    run_frame(2, 2, 4, 1, 3, 1, 4, 1'b0, "R10 config hold");

    // Constrained random frames
    for (int i = 0; i < 16; i++) begin
      run_frame(1 + int'($urandom % 4), int'($urandom % 3),
                1 + int'($urandom % 5), int'($urandom % 3),
                int'($urandom % 4), int'($urandom % 4), int'($urandom % 5),
                bit'($urandom % 2), "R8 random frame");
    end
    repeat (2) @(negedge clk);
    chk_idle("R1 final rest");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule